// File: doc/BRIEF.md
# VLIW Slot Allocator

This block places operation requests into the issue slots of a very-long-instruction-word bundle while that bundle is being built. Each request carries an operation class (scalar, vector-ALU or vector-store) and a six-bit opcode. The allocator searches the slots of that class in ascending order. It grants the first slot that is both unoccupied and legal for the opcode, sets that slot's bit in a working occupancy mask, and reports the slot index one cycle later. If no slot fits, the request is refused with an error and the mask is left unchanged.

Legality depends on more than occupancy. Control-flow scalar opcodes may only use scalar slot 0. One vector-ALU lane shares an operand window with a wide vector store, so the allocator never lets both sit in the same bundle. A finalize pulse hands the working mask out as the committed bundle and starts a fresh, empty bundle. A request that arrives together with finalize is placed into that fresh bundle.

Top module: `vliw_slot_alloc`

## Requirements
- R1: After reset, rsp_valid, rsp_grant, rsp_error and commit_valid are 0, commit_mask is 0 and the working bundle is empty.
- R2: Mask bit i is scalar slot i (i < NS), bit NS+j is vector-ALU lane j (j < NV) and bit NS+NV is the vector-store slot. A request is granted the lowest-numbered slot of its class whose mask bit is clear and which is legal, and rsp_slot reports that bit position.
- R3: A request sampled with req_valid=1 produces rsp_valid=1 on the next cycle, together with either rsp_grant=1 and rsp_slot, or rsp_error=1. On a grant the chosen slot's mask bit is set.
- R4: When no slot of the class is both free and legal, rsp_error=1, rsp_grant=0, and the occupancy is unchanged.
- R5: Scalar opcodes 6'h3E (branch) and 6'h3F (call) are legal only in scalar slot 0. All other scalar opcodes are legal in any scalar slot.
- R6: A vector-store opcode with bit 5 set is wide. A wide store is refused while vector-ALU lane WIN_LANE (default 1) is occupied, and that lane is refused while a wide store is in the bundle. Other lanes and narrow stores are not affected.
- R7: A finalize sampled high produces commit_valid=1 on the next cycle, with commit_mask equal to the occupancy before that edge. The working bundle is emptied at the same edge.
- R8: A request sampled in the same cycle as finalize is judged against, and recorded in, the new empty bundle.
- R9: req_class value 3 is reserved. Such a request gets rsp_error=1 and changes no occupancy.
- R10: A cycle with req_valid=0 gives rsp_valid=0, rsp_grant=0 and rsp_error=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 2 | 0 scalar, 1 vector-ALU, 2 vector-store, 3 reserved |
| req_opcode | input | 6 | Operation opcode |
| finalize | input | 1 | Close the current bundle and start a new one |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_grant | output | 1 | Request was placed |
| rsp_error | output | 1 | No free and legal slot |
| rsp_slot | output | SLOT_W | Mask bit position of the granted slot |
| commit_valid | output | 1 | Committed bundle mask present |
| commit_mask | output | MASK_W | Occupancy of the closed bundle |

## Verification
The bench builds the block with its defaults: two scalar slots, two vector-ALU lanes and the shared window on lane 1. This five-bit mask is small enough for short directed sequences to fill every class, to push control-flow opcodes against an occupied slot 0, and to reach both orderings of the window conflict. A long random phase then mixes classes, opcodes and finalize pulses, so finalize lands on full, partial and empty bundles, including the same cycle as a request.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
    localparam int OPC_W = 6;

    typedef enum logic [1:0] {
        CLS_SCALAR = 2'd0,
        CLS_VALU   = 2'd1,
        CLS_VSTORE = 2'd2,
        CLS_RSVD   = 2'd3
    } op_class_e;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h3E;
    localparam logic [OPC_W-1:0] OPC_CALL   = 6'h3F;
    localparam int WIDE_BIT = OPC_W - 1;

    function automatic logic is_ctrl_flow(input logic [OPC_W-1:0] opc);
        return (opc == OPC_BRANCH) || (opc == OPC_CALL);
    endfunction
endpackage

// File: rtl/slot_legal.sv
module slot_legal
    import slot_alloc_pkg::*;
#(
    parameter int NS       = 2,
    parameter int NV       = 2,
    parameter int WIN_LANE = 1,
    localparam int NSLOT   = NS + NV + 1
) (
    input  op_class_e        cls,
    input  logic [OPC_W-1:0] opcode,
    input  logic [NSLOT-1:0] occ,
    input  logic             wide_held,
    output logic [NSLOT-1:0] legal
);
    localparam int WIN_BIT = NS + WIN_LANE;
    localparam int ST_BIT  = NS + NV;

    logic ctrl;
    logic wide;
    assign ctrl = is_ctrl_flow(opcode);
    assign wide = opcode[WIDE_BIT];

    for (genvar s = 0; s < NS; s++) begin : g_scalar
        if (s == 0) begin : g_seq
            assign legal[s] = (cls == CLS_SCALAR);
        end else begin : g_plain
            assign legal[s] = (cls == CLS_SCALAR) && !ctrl;
        end
    end

    for (genvar v = 0; v < NV; v++) begin : g_valu
        if (v == WIN_LANE) begin : g_win
            assign legal[NS+v] = (cls == CLS_VALU) && !wide_held;
        end else begin : g_free
            assign legal[NS+v] = (cls == CLS_VALU);
        end
    end

    assign legal[ST_BIT] = (cls == CLS_VSTORE) && !(wide && occ[WIN_BIT]);
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int N     = 5,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
        found  = |cand;
        onehot = found ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/vliw_slot_alloc.sv
module vliw_slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NS       = 2,
    parameter int NV       = 2,
    parameter int WIN_LANE = 1,
    localparam int MASK_W  = NS + NV + 1,
    localparam int SLOT_W  = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_class,
    input  logic [5:0]        req_opcode,
    input  logic              finalize,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_error,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic              commit_valid,
    output logic [MASK_W-1:0] commit_mask
);
    localparam int WIN_BIT = NS + WIN_LANE;

    typedef struct packed {
        logic [MASK_W-1:0] occ;
        logic              wide;
        logic              rsp_valid;
        logic              rsp_grant;
        logic              rsp_error;
        logic [SLOT_W-1:0] rsp_slot;
        logic              commit_valid;
        logic [MASK_W-1:0] commit_mask;
    } state_t;

    state_t st_d, st_q;

    op_class_e         cls;
    logic [MASK_W-1:0] base_occ;
    logic              base_wide;
    logic [MASK_W-1:0] legal;
    logic [MASK_W-1:0] cand;
    logic              found;
    logic [SLOT_W-1:0] pick_idx;
    logic [MASK_W-1:0] pick_oh;

    assign cls       = op_class_e'(req_class);
    assign base_occ  = finalize ? '0 : st_q.occ;
    assign base_wide = finalize ? 1'b0 : st_q.wide;

    slot_legal #(.NS(NS), .NV(NV), .WIN_LANE(WIN_LANE)) u_legal (
        .cls       (cls),
        .opcode    (req_opcode),
        .occ       (base_occ),
        .wide_held (base_wide),
        .legal     (legal)
    );

    assign cand = legal & ~base_occ;

    slot_pick #(.N(MASK_W)) u_pick (
        .cand   (cand),
        .found  (found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    always_comb begin
        st_d              = st_q;
        st_d.occ          = base_occ;
        st_d.wide         = base_wide;
        st_d.rsp_valid    = req_valid;
        st_d.rsp_grant    = 1'b0;
        st_d.rsp_error    = 1'b0;
        st_d.rsp_slot     = '0;
        st_d.commit_valid = finalize;
        st_d.commit_mask  = finalize ? st_q.occ : '0;
        if (req_valid) begin
            if (found) begin
                st_d.rsp_grant = 1'b1;
                st_d.rsp_slot  = pick_idx;
                st_d.occ       = base_occ | pick_oh;
                if (cls == CLS_VSTORE && req_opcode[WIDE_BIT]) st_d.wide = 1'b1;
            end else begin
                st_d.rsp_error = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_grant    = st_q.rsp_grant;
    assign rsp_error    = st_q.rsp_error;
    assign rsp_slot     = st_q.rsp_slot;
    assign commit_valid = st_q.commit_valid;
    assign commit_mask  = st_q.commit_mask;

    // R3: a granted slot is recorded as occupied
    a_r3_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> ((st_q.occ & (MASK_W'(1) << rsp_slot)) != '0));

    // R2: a grant only lands on a slot that was free beforehand
    a_r2_grant_was_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant && !$past(finalize)) |->
            (($past(st_q.occ) & (MASK_W'(1) << rsp_slot)) == '0));

    // R4: a refused request leaves occupancy alone
    a_r4_error_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_error && !$past(finalize)) |-> (st_q.occ == $past(st_q.occ)));

    // R3 and R4: at most one outcome per response
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_grant, rsp_error}));

    // R5: control-flow scalar ops only in slot 0
    a_r5_ctrl_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant && $past(req_class) == 2'd0 && is_ctrl_flow($past(req_opcode)))
            |-> (rsp_slot == '0));

    // R6: shared window never doubly claimed
    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.wide && st_q.occ[WIN_BIT]));

    // R7: an idle finalize leaves an empty bundle
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(finalize) && !$past(req_valid)) |-> (st_q.occ == '0));

    // R10: no response without a request
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !rsp_valid && !rsp_grant && !rsp_error);
endmodule

// File: tb/vliw_slot_alloc_tb.sv
module vliw_slot_alloc_tb;
    localparam int NS = 2;
    localparam int NV = 2;
    localparam int MW = NS + NV + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = '0;
    logic [5:0] req_opcode = '0;
    logic       finalize = 1'b0;
    logic       rsp_valid, rsp_grant, rsp_error, commit_valid;
    logic [2:0] rsp_slot;
    logic [MW-1:0] commit_mask;

    int checks = 0;
    int fails  = 0;

    logic [MW-1:0] m_occ = '0;
    logic          m_wide = 1'b0;

    always #4 clk = ~clk;

    vliw_slot_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_opcode(req_opcode), .finalize(finalize), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_error(rsp_error), .rsp_slot(rsp_slot),
        .commit_valid(commit_valid), .commit_mask(commit_mask)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic v, input logic [1:0] c,
                        input logic [5:0] o, input logic f);
        logic [MW-1:0] base;
        logic          bw, g, e;
        int            slot;
        @(negedge clk);
        req_valid = v; req_class = c; req_opcode = o; finalize = f;
        base = f ? '0 : m_occ;
        bw   = f ? 1'b0 : m_wide;
        g = 1'b0; e = 1'b0; slot = -1;
        if (v) begin
            if (c == 2'd0) begin
                for (int s = 0; s < NS; s++)
                    if (slot < 0 && !base[s] && (s == 0 || !(o == 6'h3E || o == 6'h3F))) slot = s;
            end else if (c == 2'd1) begin
                for (int j = 0; j < NV; j++)
                    if (slot < 0 && !base[NS+j] && !(j == 1 && bw)) slot = NS + j;
            end else if (c == 2'd2) begin
                if (!base[NS+NV] && !(o[5] && base[NS+1])) slot = NS + NV;
            end
            g = (slot >= 0);
            e = !g;
        end
        @(posedge clk);
        #1;
        check(req, {rsp_valid, rsp_grant, rsp_error, (rsp_grant ? rsp_slot : 3'd0),
                    commit_valid, (commit_valid ? commit_mask : 5'd0)},
              {v, g, e, (g ? 3'(slot) : 3'd0), f, (f ? m_occ : 5'd0)});
        m_occ  = g ? (base | (MW'(1) << slot)) : base;
        m_wide = bw | (g && c == 2'd2 && o[5]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {rsp_valid, rsp_grant, rsp_error, commit_valid, 11'(commit_mask)}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 first-fit in each class, R4 scalar class full
        step("R2", 1, 0, 6'h01, 0);
        step("R2", 1, 0, 6'h02, 0);
        step("R4", 1, 0, 6'h03, 0);
        step("R2", 1, 1, 6'h04, 0);
        step("R2", 1, 1, 6'h05, 0);
        step("R4", 1, 1, 6'h06, 0);
        step("R3", 1, 2, 6'h01, 0);
        step("R7", 0, 0, 6'h00, 1);
        step("R10", 0, 0, 6'h00, 0);
        // R5 control flow confined to slot 0
        step("R5", 1, 0, 6'h3E, 0);
        step("R5", 1, 0, 6'h3F, 0);
        step("R5", 1, 0, 6'h10, 0);
        step("R7", 0, 0, 6'h00, 1);
        step("R5", 1, 0, 6'h10, 0);
        step("R5", 1, 0, 6'h3F, 0);
        // R8 request alongside finalize lands in new bundle
        step("R8", 1, 0, 6'h3F, 1);
        step("R8", 1, 0, 6'h3E, 1);
        // R6 window conflict both orders
        step("R7", 0, 0, 6'h00, 1);
        step("R6", 1, 1, 6'h01, 0);
        step("R6", 1, 1, 6'h01, 0);
        step("R6", 1, 2, 6'h20, 0);
        step("R6", 1, 2, 6'h20, 1);
        step("R6", 1, 1, 6'h02, 0);
        step("R6", 1, 1, 6'h02, 0);
        step("R6", 0, 0, 6'h00, 1);
        step("R6", 1, 1, 6'h02, 0);
        step("R6", 1, 1, 6'h02, 0);
        step("R6", 1, 2, 6'h05, 0);
        // R9 reserved class
        step("R9", 1, 3, 6'h00, 0);
        step("R9", 1, 0, 6'h00, 1);
        step("R9", 1, 3, 6'h3F, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0] op;
            op = 6'($urandom);
            if ($urandom_range(0, 3) == 0) op = 6'h3E | 6'($urandom_range(0, 1));
            step("R2", 1'($urandom_range(0, 4) != 0), 2'($urandom), op,
                 ($urandom_range(0, 5) == 0));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule